// File: doc/BRIEF.md
# Keyed System Control Register Bank

This block is the control and status register file of a processor core module. It sits on a simple word-addressed bus with separate read and write strobes. It holds two clock-synthesizer words that software may change only after writing an unlock key. It also holds the following:

- a control word whose bits drive the boot memory remap and request a system reset;
- two flag words, each with its own set address and clear address;
- memory-configuration words that are stored only;
- a free-running reference counter;
- a read-only window of serial-presence-detect bytes.

A tick-enable input advances the counter once per reference period, so the bank can run on any faster system clock. Read data is registered and appears on the cycle after a read strobe. Write effects take hold at the clock edge that samples the write strobe. The remap output is a level. The reset request is a pulse that lasts exactly one cycle.

Top module: `sysctl_bank`

## Requirements
- R1: Word 0 always reads 0x411A3001 and word 4 always reads 0x00100000. Word 1 reads 0. Writes to these words change nothing.
- R2: After reset the registers hold these values: oscillator (word 2) 0x01000048, auxiliary oscillator (word 7) 0x0007FEFF, SDRAM word (word 8) 0x00011122 OR a size code, init word (word 9) 0x00000112. The lock word, control word, flags, counter and read data are all 0, and `remap_o` and `rst_req_o` are low. The size code depends on MEM_MB: 0x10 for 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 otherwise. With the default MEM_MB of 16 the code is 0.
- R3: The lock word (word 5) keeps only the low 16 bits written. While it holds 0xA05F it reads 0x0001A05F; otherwise it reads its stored value.
- R4: Writes to word 2 and word 7 update the register only while the lock word holds 0xA05F. At any other time these writes are dropped.
- R5: In the control word (word 3) only bits 0 and 2 are stored. All other bits read as 0, and this includes bit 3.
- R6: A write to word 3 with bit 3 set drives `rst_req_o` high for exactly one cycle, the cycle that follows the write edge. `rst_req_o` is low at every other time.
- R7: `remap_o` follows stored control bit 2. A value of 1 means the boot flash window is disabled and RAM appears at address zero.
- R8: Writing word 12 ORs the data into the volatile flags, and writing word 13 clears the bits that are set in the data. Words 14 and 15 do the same for the non-volatile flags. Words 12 and 14 read the current flags, and the two flag sets are independent.
- R9: Word 10 reads a counter that increments by one in each cycle where `tick_i` is high and holds in every other cycle. It wraps modulo 2^32.
- R10: Word 8 and word 9 store all 32 bits written, with no lock.
- R11: Word addresses 64 to 95 return, zero-extended, the byte of an internal 128-entry table indexed by the word address. Entries 73 to 83 hold the ASCII text "CORE-MEMORY" and all other entries are 0. Words 96 to 127 read 0.
- R12: Any word not listed above reads 0 and ignores writes. Examples are 6, 16 and 100.
- R13: `rdata_o` loads the addressed value on a clock edge where `rd_en_i` is high, and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Reference-rate count enable, one cycle per reference period |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W (7) | Word address |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |
| remap_o | output | 1 | High when RAM replaces boot flash at address zero |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Every register effect is due one clock edge after its stimulus.

- **Reads:** `rdata_o` carries the value of the word addressed at the edge that sampled `rd_en_i`.
- **Writes:** a stored value, the `remap_o` level and the rise of `rst_req_o` are all visible in the cycle after the write edge. The reset pulse has fallen one cycle later.

The bench changes inputs on falling edges and samples outputs at the next falling edge, so each check lands half a period after the edge that produced its value. Counter checks count the cycles in which `tick_i` was held high before the read, and the read itself is issued with `tick_i` low.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // Word addresses whose position is fixed by software.
  localparam int WA_ID      = 0;
  localparam int WA_PROC    = 1;
  localparam int WA_OSC     = 2;
  localparam int WA_CTRL    = 3;
  localparam int WA_STAT    = 4;
  localparam int WA_LOCK    = 5;
  localparam int WA_AUXOSC  = 7;
  localparam int WA_SDRAM   = 8;
  localparam int WA_INIT    = 9;
  localparam int WA_REFCNT  = 10;
  localparam int WA_FLAG0   = 12;  // bank g: set at WA_FLAG0+2g, clear at +1
  localparam int WA_SPD_LO  = 64;
  localparam int WA_SPD_HI  = 96;  // exclusive

  localparam logic [31:0] ID_VALUE    = 32'h411A_3001;
  localparam logic [31:0] STAT_VALUE  = 32'h0010_0000;
  localparam logic [15:0] UNLOCK_KEY  = 16'hA05F;
  localparam logic [31:0] OSC_INIT    = 32'h0100_0048;
  localparam logic [31:0] AUXOSC_INIT = 32'h0007_FEFF;
  localparam logic [31:0] SDRAM_INIT  = 32'h0001_1122;
  localparam logic [31:0] INIT_INIT   = 32'h0000_0112;

  localparam logic [31:0] CTRL_KEEP   = 32'h0000_0005;
  localparam int          CTRL_REMAP  = 2;
  localparam int          CTRL_RESET  = 3;

  localparam int          TAG_FIRST   = 73;
  localparam int          TAG_LEN     = 11;
  localparam logic [8*TAG_LEN-1:0] SPD_TAG = "CORE-MEMORY";

  // Size field merged into the SDRAM word at reset.
  function automatic logic [31:0] sdram_size_code(input int mem_mb);
    if (mem_mb >= 256)     return 32'h10;
    else if (mem_mb >= 128) return 32'h0C;
    else if (mem_mb >= 64)  return 32'h08;
    else if (mem_mb >= 32)  return 32'h04;
    return 32'h00;
  endfunction

  // Presence-detect table entry; only the tag bytes are non-zero.
  function automatic logic [7:0] spd_byte(input int idx);
    if (idx >= TAG_FIRST && idx < TAG_FIRST + TAG_LEN)
      return SPD_TAG[8*(TAG_FIRST + TAG_LEN - 1 - idx) +: 8];
    return 8'h00;
  endfunction

endpackage

// File: rtl/sysctl_keyreg.sv
module sysctl_keyreg #(
  parameter int                DATA_W   = 32,
  parameter int                KEY_W    = 16,
  parameter logic [KEY_W-1:0]  KEY      = 16'hA05F,
  parameter logic [DATA_W-1:0] OSC_RST  = '0,
  parameter logic [DATA_W-1:0] AUX_RST  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lock_i,
  input  logic              wr_osc_i,
  input  logic              wr_aux_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [KEY_W-1:0]  lock_o,
  output logic              unlocked_o,
  output logic [DATA_W-1:0] osc_o,
  output logic [DATA_W-1:0] aux_o
);

  logic [KEY_W-1:0]  lock_q, lock_d;
  logic [DATA_W-1:0] osc_q, osc_d, aux_q, aux_d;
  logic              open_w;

  assign open_w = (lock_q == KEY);

  always_comb begin
    lock_d = wr_lock_i ? wdata_i[KEY_W-1:0] : lock_q;
    osc_d  = (wr_osc_i && open_w) ? wdata_i : osc_q;
    aux_d  = (wr_aux_i && open_w) ? wdata_i : aux_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
      osc_q  <= OSC_RST;
      aux_q  <= AUX_RST;
    end else begin
      lock_q <= lock_d;
      osc_q  <= osc_d;
      aux_q  <= aux_d;
    end
  end

  assign lock_o     = lock_q;
  assign unlocked_o = open_w;
  assign osc_o      = osc_q;
  assign aux_o      = aux_q;

endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (set_i)      q_d = q_q | data_i;
    else if (clr_i) q_d = q_q & ~data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

endmodule

// File: rtl/sysctl_refcnt.sv
module sysctl_refcnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q, cnt_d;

  assign cnt_d = tick_i ? cnt_q + W'(1) : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W       = 7,
  parameter int DATA_W       = 32,
  parameter int KEY_W        = 16,
  parameter int MEM_MB       = 16,
  parameter int N_FLAG_BANKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              remap_o,
  output logic              rst_req_o
);

  localparam int                N_WORDS   = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] SDRAM_RST = DATA_W'(SDRAM_INIT | sdram_size_code(MEM_MB));

  // Write decode: one-hot per word address.
  logic [N_WORDS-1:0] wr_hit;
  always_comb begin
    wr_hit = '0;
    if (wr_en_i) wr_hit[addr_i] = 1'b1;
  end

  // Keyed clock-synthesizer words.
  logic [KEY_W-1:0]  lock_q;
  logic              unlocked;
  logic [DATA_W-1:0] osc_q, aux_q;

  sysctl_keyreg #(
    .DATA_W (DATA_W),
    .KEY_W  (KEY_W),
    .KEY    (KEY_W'(UNLOCK_KEY)),
    .OSC_RST(DATA_W'(OSC_INIT)),
    .AUX_RST(DATA_W'(AUXOSC_INIT))
  ) u_keyreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lock_i (wr_hit[WA_LOCK]),
    .wr_osc_i  (wr_hit[WA_OSC]),
    .wr_aux_i  (wr_hit[WA_AUXOSC]),
    .wdata_i   (wdata_i),
    .lock_o    (lock_q),
    .unlocked_o(unlocked),
    .osc_o     (osc_q),
    .aux_o     (aux_q)
  );

  // Set/clear flag banks.
  logic [DATA_W-1:0] flag_q [N_FLAG_BANKS];

  for (genvar g = 0; g < N_FLAG_BANKS; g++) begin : g_flags
    sysctl_setclr #(.W(DATA_W)) u_flags (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (wr_hit[WA_FLAG0 + 2*g]),
      .clr_i (wr_hit[WA_FLAG0 + 2*g + 1]),
      .data_i(wdata_i),
      .q_o   (flag_q[g])
    );
  end

  // Reference counter.
  logic [DATA_W-1:0] cnt_q;

  sysctl_refcnt #(.W(DATA_W)) u_refcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .cnt_o (cnt_q)
  );

  // Control, memory-configuration words, reset pulse and read data.
  logic [DATA_W-1:0] ctrl_q, ctrl_d, sdram_q, sdram_d, init_q, init_d;
  logic [DATA_W-1:0] rdata_q, rdata_d, rd_mux;
  logic              rst_req_q, rst_req_d;

  always_comb begin
    ctrl_d    = wr_hit[WA_CTRL]  ? (wdata_i & DATA_W'(CTRL_KEEP)) : ctrl_q;
    rst_req_d = wr_hit[WA_CTRL] & wdata_i[CTRL_RESET];
    sdram_d   = wr_hit[WA_SDRAM] ? wdata_i : sdram_q;
    init_d    = wr_hit[WA_INIT]  ? wdata_i : init_q;
  end

  always_comb begin
    rd_mux = '0;
    case (int'(addr_i))
      WA_ID:     rd_mux = DATA_W'(ID_VALUE);
      WA_PROC:   rd_mux = '0;
      WA_OSC:    rd_mux = osc_q;
      WA_CTRL:   rd_mux = ctrl_q;
      WA_STAT:   rd_mux = DATA_W'(STAT_VALUE);
      WA_LOCK:   rd_mux = DATA_W'({unlocked, lock_q});
      WA_AUXOSC: rd_mux = aux_q;
      WA_SDRAM:  rd_mux = sdram_q;
      WA_INIT:   rd_mux = init_q;
      WA_REFCNT: rd_mux = cnt_q;
      default:   rd_mux = '0;
    endcase
    for (int g = 0; g < N_FLAG_BANKS; g++) begin
      if (int'(addr_i) == WA_FLAG0 + 2*g) rd_mux = flag_q[g];
    end
    if (int'(addr_i) >= WA_SPD_LO && int'(addr_i) < WA_SPD_HI)
      rd_mux = DATA_W'(spd_byte(int'(addr_i)));
  end

  assign rdata_d = rd_en_i ? rd_mux : rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      rst_req_q <= 1'b0;
      sdram_q   <= SDRAM_RST;
      init_q    <= DATA_W'(INIT_INIT);
      rdata_q   <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      rst_req_q <= rst_req_d;
      sdram_q   <= sdram_d;
      init_q    <= init_d;
      rdata_q   <= rdata_d;
    end
  end

  assign rdata_o   = rdata_q;
  assign remap_o   = ctrl_q[CTRL_REMAP];
  assign rst_req_o = rst_req_q;

endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              remap_o,
  input logic              rst_req_o,
  input logic [DATA_W-1:0] osc_v,
  input logic [DATA_W-1:0] cnt_v,
  input logic [DATA_W-1:0] flag0_v,
  input logic              unl_v
);

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  a_r6_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(wr_en_i && int'(addr_i) == 3 && wdata_i[3]));

  a_r4_osc_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unl_v) |=> $stable(osc_v));

  a_r7_remap_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(addr_i) == 3) |=> (remap_o == $past(wdata_i[2])));

  a_r8_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(addr_i) == 12) |=> ((flag0_v & $past(wdata_i)) == $past(wdata_i)));

  a_r9_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_v == $past(cnt_v) + DATA_W'(1)));

  a_r9_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_v));

  a_r13_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

endmodule

bind sysctl_bank sysctl_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .remap_o  (remap_o),
  .rst_req_o(rst_req_o),
  .osc_v    (osc_q),
  .cnt_v    (cnt_q),
  .flag0_v  (flag_q[0]),
  .unl_v    (unlocked)
);

// File: tb/sysctl_bank_tb_top.sv
module sysctl_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV         = 52;

  typedef struct packed {
    logic        wr;
    logic [3:0]  req;
    logic [6:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  // wr=1: write data; wr=0: read and compare with exp. req names the requirement.
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd1,  7'd0,   32'h0,        32'h411A3001}, // R1
    '{1'b1, 4'd1,  7'd0,   32'hFFFFFFFF, 32'h0},
    '{1'b0, 4'd1,  7'd0,   32'h0,        32'h411A3001}, // R1 write ignored
    '{1'b0, 4'd1,  7'd4,   32'h0,        32'h00100000},
    '{1'b0, 4'd1,  7'd1,   32'h0,        32'h0},
    '{1'b0, 4'd2,  7'd2,   32'h0,        32'h01000048}, // R2 reset values
    '{1'b0, 4'd2,  7'd7,   32'h0,        32'h0007FEFF},
    '{1'b0, 4'd2,  7'd8,   32'h0,        32'h00011122},
    '{1'b0, 4'd2,  7'd9,   32'h0,        32'h00000112},
    '{1'b0, 4'd2,  7'd5,   32'h0,        32'h0},
    '{1'b0, 4'd2,  7'd3,   32'h0,        32'h0},
    '{1'b1, 4'd4,  7'd2,   32'h12345678, 32'h0},        // R4 locked write
    '{1'b0, 4'd4,  7'd2,   32'h0,        32'h01000048},
    '{1'b1, 4'd3,  7'd5,   32'hFFFFA05F, 32'h0},        // R3 key
    '{1'b0, 4'd3,  7'd5,   32'h0,        32'h0001A05F},
    '{1'b1, 4'd4,  7'd2,   32'h12345678, 32'h0},
    '{1'b0, 4'd4,  7'd2,   32'h0,        32'h12345678},
    '{1'b1, 4'd4,  7'd7,   32'h0000ABCD, 32'h0},
    '{1'b0, 4'd4,  7'd7,   32'h0,        32'h0000ABCD},
    '{1'b1, 4'd3,  7'd5,   32'h0001A05E, 32'h0},        // R3 wrong key
    '{1'b0, 4'd3,  7'd5,   32'h0,        32'h0000A05E},
    '{1'b1, 4'd4,  7'd7,   32'h00000001, 32'h0},
    '{1'b0, 4'd4,  7'd7,   32'h0,        32'h0000ABCD},
    '{1'b1, 4'd5,  7'd3,   32'hFFFFFFF7, 32'h0},        // R5
    '{1'b0, 4'd5,  7'd3,   32'h0,        32'h00000005},
    '{1'b1, 4'd10, 7'd8,   32'hDEADBEEF, 32'h0},        // R10
    '{1'b0, 4'd10, 7'd8,   32'h0,        32'hDEADBEEF},
    '{1'b1, 4'd10, 7'd9,   32'hCAFEF00D, 32'h0},
    '{1'b0, 4'd10, 7'd9,   32'h0,        32'hCAFEF00D},
    '{1'b1, 4'd8,  7'd12,  32'h0000F0F0, 32'h0},        // R8
    '{1'b1, 4'd8,  7'd12,  32'h00000003, 32'h0},
    '{1'b0, 4'd8,  7'd12,  32'h0,        32'h0000F0F3},
    '{1'b1, 4'd8,  7'd13,  32'h00000030, 32'h0},
    '{1'b0, 4'd8,  7'd12,  32'h0,        32'h0000F0C3},
    '{1'b0, 4'd8,  7'd14,  32'h0,        32'h0},
    '{1'b1, 4'd8,  7'd14,  32'h80000001, 32'h0},
    '{1'b1, 4'd8,  7'd15,  32'h00000001, 32'h0},
    '{1'b0, 4'd8,  7'd14,  32'h0,        32'h80000000},
    '{1'b0, 4'd8,  7'd12,  32'h0,        32'h0000F0C3},
    '{1'b0, 4'd11, 7'd64,  32'h0,        32'h0},        // R11
    '{1'b0, 4'd11, 7'd73,  32'h0,        32'h00000043},
    '{1'b0, 4'd11, 7'd77,  32'h0,        32'h0000002D},
    '{1'b0, 4'd11, 7'd83,  32'h0,        32'h00000059},
    '{1'b0, 4'd11, 7'd84,  32'h0,        32'h0},
    '{1'b0, 4'd11, 7'd100, 32'h0,        32'h0},
    '{1'b1, 4'd12, 7'd100, 32'hFFFFFFFF, 32'h0},        // R12
    '{1'b0, 4'd12, 7'd100, 32'h0,        32'h0},
    '{1'b0, 4'd12, 7'd6,   32'h0,        32'h0},
    '{1'b1, 4'd12, 7'd16,  32'hFFFFFFFF, 32'h0},
    '{1'b0, 4'd12, 7'd16,  32'h0,        32'h0},
    '{1'b0, 4'd12, 7'd127, 32'h0,        32'h0},
    '{1'b1, 4'd5,  7'd3,   32'h00000000, 32'h0}
  };

  logic        clk_i, rst_ni, tick_i, wr_en_i, rd_en_i;
  logic [6:0]  addr_i;
  logic [31:0] wdata_i, rdata_o;
  logic        remap_o, rst_req_o;
  int          checks, errors;
  bit          done;

  sysctl_bank dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .remap_o  (remap_o),
    .rst_req_o(rst_req_o)
  );

  initial clk_i = 1'b0;
  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    checks = 0; errors = 0; done = 1'b0;
    rst_ni = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0;
    addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 output state after reset
    check("R2 rdata reset", rdata_o, 32'h0);
    check("R2 remap reset", {31'b0, remap_o}, 32'h0);
    check("R2 rst_req reset", {31'b0, rst_req_o}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr) bus_write(VECS[v].addr, VECS[v].data);
      else begin
        bus_read(VECS[v].addr, rd);
        check($sformatf("R%0d vec%0d addr%0d", VECS[v].req, v, VECS[v].addr), rd, VECS[v].exp);
      end
    end

    // R7 remap level
    bus_write(7'd3, 32'h4);
    check("R7 remap set", {31'b0, remap_o}, 32'h1);
    check("R6 no pulse without bit3", {31'b0, rst_req_o}, 32'h0);
    bus_write(7'd3, 32'h0);
    check("R7 remap clear", {31'b0, remap_o}, 32'h0);

    // R6 reset request pulse
    bus_write(7'd3, 32'h0000000D);
    check("R6 pulse high", {31'b0, rst_req_o}, 32'h1);
    @(negedge clk_i);
    check("R6 pulse one cycle", {31'b0, rst_req_o}, 32'h0);
    bus_read(7'd3, rd);
    check("R5 bit3 reads zero", rd, 32'h5);
    check("R7 remap after reset write", {31'b0, remap_o}, 32'h1);

    // R9 counter
    bus_read(7'd10, rd);
    check("R9 count start", rd, 32'h0);
    ticks(5);
    bus_read(7'd10, rd);
    check("R9 count five", rd, 32'h5);
    repeat (4) @(negedge clk_i);
    ticks(2);
    bus_read(7'd10, rd);
    check("R9 count holds between ticks", rd, 32'h7);

    // R13 rdata holds without read strobe
    @(negedge clk_i);
    addr_i = 7'd0;
    @(negedge clk_i);
    check("R13 rdata hold", rdata_o, 32'h7);

    // R2 mid-run reset restores keyed and counter state
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    bus_read(7'd5, rd);
    check("R2 lock after reset", rd, 32'h0);
    bus_read(7'd2, rd);
    check("R2 osc after reset", rd, 32'h01000048);
    bus_read(7'd10, rd);
    check("R2 counter after reset", rd, 32'h0);
    check("R2 remap after reset", {31'b0, remap_o}, 32'h0);
    bus_write(7'd2, 32'hAAAA5555);
    bus_read(7'd2, rd);
    check("R4 locked after reset", rd, 32'h01000048);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule